// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

The block is a data cache placed between a processor access port and a word-wide lower-level memory port. It holds 1024 lines of four 32-bit words each, 16 KB in total. Each 32-bit byte address is cut into a tag, a line index, a word-in-line select and a byte select. Every line keeps a valid flag and a stored tag. A read that hits is answered in the same cycle. A read that misses holds the processor off while all four words of the block are fetched. The access is then retried and completes as a hit.

Writes update the cached word and also go into a four-entry first-in first-out write buffer. The buffer empties itself to memory in the background. A write that misses first brings the whole block into the line, and the write then lands in it as a hit. The processor waits only when the buffer has no free slot. The memory port carries one word per transaction. A block refill never shares the port with a buffer write, and a refill begins only after the buffer has emptied, so the refill always sees the newest data.

Top module: `wt_dcache`

## Requirements
- R1: After reset every line is invalid, no memory request is raised, and the first access to any line misses.
- R2: The tag is address bits [31:14], the index bits [13:4], the word select bits [3:2] and the byte select bits [1:0]. A hit needs the indexed line to be valid and its stored tag to equal the address tag. A miss to a line that holds another tag replaces that line.
- R3: A read miss keeps ready_o low and issues exactly four memory reads, at block base +0, +4, +8 and +12 in that order. The access then completes with the word from memory.
- R4: A read hit asserts ready_o in the cycle it is requested and returns the cached word. It causes no memory traffic.
- R5: A write hit updates the cached word, so later reads return the new value, and the write also reaches lower memory.
- R6: The write buffer holds 4 entries. A write hit completes at once while a slot is free, and waits with ready_o low while the buffer is full. An entry frees its slot when its memory write is acknowledged.
- R7: Buffered writes reach memory in the order the processor issued them. After repeated writes to one address, memory holds the last value written.
- R8: A write miss first refills the block with four memory reads and then merges the written word. The other words of the block keep their memory values.
- R9: A read miss to a block that still has an entry pending in the write buffer returns the buffered (newest) value.
- R10: A memory transaction holds its address, direction and write data steady until it is acknowledged. A buffer write never starts while a block refill is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Access completes at this clock edge |
| rdata_o | output | 32 | Read data, valid when ready_o is high on a read |
| mem_req_o | output | 1 | Memory transaction request, held until acknowledged |
| mem_we_o | output | 1 | Memory transaction is a write |
| mem_addr_o | output | 32 | Memory word address (byte-aligned) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory transaction done this cycle |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_ack_i |

## Verification
The bench goes after aliasing in the line index. It reads two addresses that share an index but differ in tag, and then rereads the first. A design that compared too few tag bits would return the wrong block as a hit. Write bursts are run against a deliberately slow memory. A buffer that overflowed would lose a write or reorder the drain, and a buffer that stalled too early would hold the processor on writes that should have completed at once. The sharpest case is a read miss issued while a write to the same block is still buffered. A design that started the refill early would return stale memory data. The bench also checks the refill word order and the merge after a write miss. Every clock it checks that a memory transaction does not change before its acknowledge.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FILL = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/wt_dcache_store.sv
module wt_dcache_store #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 18,
  parameter int IDX_W  = 10,
  parameter int WOFF_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [WOFF_W-1:0] lk_woff_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WOFF_W-1:0] wr_woff_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tag_set_i,
  input  logic [IDX_W-1:0]  tag_idx_i,
  input  logic [TAG_W-1:0]  tag_val_i
);
  localparam int LINES  = 1 << IDX_W;
  localparam int WORDS  = 1 << WOFF_W;
  localparam int LINE_W = WORDS * DATA_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (tag_set_i) valid_q[tag_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (tag_set_i) tag_q[tag_idx_i] <= tag_val_i;
    if (wr_en_i) data_q[wr_idx_i][wr_woff_i*DATA_W +: DATA_W] <= wr_data_i;
  end

  assign hit_o   = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
  assign rdata_o = data_q[lk_idx_i][lk_woff_i*DATA_W +: DATA_W];
endmodule

// File: rtl/wt_dcache_wbuf.sv
module wt_dcache_wbuf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [DATA_W-1:0] head_data_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      data_q[wr_ptr_q] <= push_data_i;
    end
  end

  assign full_o      = (cnt_q == CNT_W'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R7
endmodule

// File: rtl/wt_dcache_ctrl.sv
module wt_dcache_ctrl
  import wt_dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10,
  parameter int WOFF_W = 2,
  parameter int BOFF_W = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_i,
  input  logic                             we_i,
  input  logic [ADDR_W-WOFF_W-BOFF_W-1:0]  blk_i,
  input  logic                             hit_i,
  input  logic                             wb_full_i,
  input  logic                             wb_empty_i,
  input  logic [ADDR_W-1:0]                wb_addr_i,
  input  logic [DATA_W-1:0]                wb_data_i,
  output logic                             wb_pop_o,
  output logic                             ready_o,
  output logic                             fill_we_o,
  output logic [IDX_W-1:0]                 fill_idx_o,
  output logic [WOFF_W-1:0]                fill_woff_o,
  output logic                             fill_done_o,
  output logic [ADDR_W-WOFF_W-BOFF_W-IDX_W-1:0] fill_tag_o,
  output logic                             mem_req_o,
  output logic                             mem_we_o,
  output logic [ADDR_W-1:0]                mem_addr_o,
  output logic [DATA_W-1:0]                mem_wdata_o,
  input  logic                             mem_ack_i
);
  localparam int BLK_W = ADDR_W - WOFF_W - BOFF_W;
  localparam int TAG_W = BLK_W - IDX_W;

  ctrl_state_e       st_q;
  logic [BLK_W-1:0]  blk_q;
  logic [WOFF_W-1:0] cnt_q;
  logic              wb_busy_q;
  logic              miss, wb_idle, wb_start, last_word;

  assign miss      = (st_q == ST_IDLE) && req_i && !hit_i;
  assign wb_idle   = wb_empty_i && !wb_busy_q;
  assign wb_start  = !wb_busy_q && !wb_empty_i && (st_q != ST_FILL);
  assign last_word = (cnt_q == {WOFF_W{1'b1}});
  assign ready_o   = (st_q == ST_IDLE) && req_i && hit_i && (!we_i || !wb_full_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      blk_q     <= '0;
      cnt_q     <= '0;
      wb_busy_q <= 1'b0;
    end else begin
      if (wb_start) wb_busy_q <= 1'b1;
      else if (wb_busy_q && mem_ack_i) wb_busy_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (miss) begin
          blk_q <= blk_i;
          cnt_q <= '0;
          st_q  <= wb_idle ? ST_FILL : ST_WAIT;
        end
        ST_WAIT: if (wb_idle) st_q <= ST_FILL;
        ST_FILL: if (mem_ack_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_word) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = {blk_q, cnt_q, {BOFF_W{1'b0}}};
    mem_wdata_o = wb_data_i;
    if (st_q == ST_FILL) begin
      mem_req_o = 1'b1;
    end else if (wb_busy_q) begin
      mem_req_o  = 1'b1;
      mem_we_o   = 1'b1;
      mem_addr_o = wb_addr_i;
    end
  end

  assign wb_pop_o    = wb_busy_q && mem_ack_i && (st_q != ST_FILL);
  assign fill_we_o   = (st_q == ST_FILL) && mem_ack_i;
  assign fill_done_o = fill_we_o && last_word;
  assign fill_idx_o  = blk_q[IDX_W-1:0];
  assign fill_tag_o  = blk_q[BLK_W-1:IDX_W];
  assign fill_woff_o = cnt_q;

  AST_PORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((st_q == ST_FILL) && wb_busy_q)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R10
  AST_FILL_AFTER_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FILL) |-> wb_empty_i); // R9
  AST_MISS_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !hit_i) |-> !ready_o); // R3
  initial assert (TAG_W > 0);
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 10,
  parameter int WOFF_W   = 2,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int BOFF_W = $clog2(DATA_W / 8);
  localparam int BLK_W  = ADDR_W - WOFF_W - BOFF_W;
  localparam int TAG_W  = BLK_W - IDX_W;

  logic [IDX_W-1:0]  a_idx;
  logic [WOFF_W-1:0] a_woff;
  logic [TAG_W-1:0]  a_tag;
  logic              unused_boff;
  logic              hit, cpu_wr;
  logic              wb_full, wb_empty, wb_pop;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;
  logic              fill_we, fill_done;
  logic [IDX_W-1:0]  fill_idx;
  logic [WOFF_W-1:0] fill_woff;
  logic [TAG_W-1:0]  fill_tag;

  assign a_woff      = addr_i[BOFF_W +: WOFF_W];
  assign a_idx       = addr_i[BOFF_W+WOFF_W +: IDX_W];
  assign a_tag       = addr_i[ADDR_W-1 -: TAG_W];
  assign unused_boff = ^addr_i[BOFF_W-1:0];
  assign cpu_wr      = ready_o && we_i;

  wt_dcache_store #(.DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .WOFF_W(WOFF_W)) store_i (
    .clk_i, .rst_ni,
    .lk_idx_i  (a_idx),
    .lk_tag_i  (a_tag),
    .lk_woff_i (a_woff),
    .hit_o     (hit),
    .rdata_o   (rdata_o),
    .wr_en_i   (cpu_wr || fill_we),
    .wr_idx_i  (fill_we ? fill_idx : a_idx),
    .wr_woff_i (fill_we ? fill_woff : a_woff),
    .wr_data_i (fill_we ? mem_rdata_i : wdata_i),
    .tag_set_i (fill_done),
    .tag_idx_i (fill_idx),
    .tag_val_i (fill_tag)
  );

  wt_dcache_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) wbuf_i (
    .clk_i, .rst_ni,
    .push_i      (cpu_wr),
    .push_addr_i ({addr_i[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}}),
    .push_data_i (wdata_i),
    .pop_i       (wb_pop),
    .full_o      (wb_full),
    .empty_o     (wb_empty),
    .head_addr_o (wb_addr),
    .head_data_o (wb_data)
  );

  wt_dcache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
                   .WOFF_W(WOFF_W), .BOFF_W(BOFF_W)) ctrl_i (
    .clk_i, .rst_ni,
    .req_i, .we_i,
    .blk_i       (addr_i[ADDR_W-1:BOFF_W+WOFF_W]),
    .hit_i       (hit),
    .wb_full_i   (wb_full),
    .wb_empty_i  (wb_empty),
    .wb_addr_i   (wb_addr),
    .wb_data_i   (wb_data),
    .wb_pop_o    (wb_pop),
    .ready_o     (ready_o),
    .fill_we_o   (fill_we),
    .fill_idx_o  (fill_idx),
    .fill_woff_o (fill_woff),
    .fill_done_o (fill_done),
    .fill_tag_o  (fill_tag),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ack_i
  );

  AST_RESET_NO_REQ: assert property (@(posedge clk_i) $rose(rst_ni) |-> !mem_req_o); // R1
endmodule

// File: tb/wt_dcache_tb_top.sv
module wt_dcache_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic        ready;
  logic [31:0] rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int errors = 0, checks = 0;
  int lat = 2;
  int mcnt = 0;
  bit done = 1'b0;

  logic [31:0] mem_model [logic [31:0]];
  logic [31:0] ref_mem   [logic [31:0]];
  logic [31:0] rd_log[$];
  logic [31:0] wr_log_a[$], wr_log_d[$];
  logic [31:0] iss_a[$], iss_d[$];

  logic        p_pend = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0, p_wdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wt_dcache dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .rdata_o(rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] init_val(logic [31:0] a);
    return a ^ 32'hC3C3_0000;
  endfunction

  function automatic logic [31:0] mem_get(logic [31:0] a);
    if (mem_model.exists(a)) return mem_model[a];
    return init_val(a);
  endfunction

  function automatic logic [31:0] ref_get(logic [31:0] a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return init_val(a);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and per-clock port-stability comparison (R10)
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; mcnt = 0; p_pend = 1'b0;
    end else begin
      if (p_pend) begin
        checks++;
        if (!mem_req || mem_we !== p_we || mem_addr !== p_addr || (p_we && mem_wdata !== p_wdata)) begin
          errors++;
          $display("FAIL R10 request changed before ack actual=%h/%b expected=%h/%b",
                   mem_addr, mem_we, p_addr, p_we);
        end
      end
      if (mem_ack) begin
        mem_ack = 1'b0; mcnt = 0; p_pend = 1'b0;
      end else if (mem_req) begin
        mcnt++;
        if (mcnt >= lat) begin
          mem_ack = 1'b1;
          p_pend = 1'b0;
          if (mem_we) begin
            mem_model[mem_addr] = mem_wdata;
            wr_log_a.push_back(mem_addr);
            wr_log_d.push_back(mem_wdata);
          end else begin
            mem_rdata = mem_get(mem_addr);
            rd_log.push_back(mem_addr);
          end
        end else begin
          p_pend = 1'b1; p_we = mem_we; p_addr = mem_addr; p_wdata = mem_wdata;
        end
      end
    end
  end

  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    cyc = 0;
    #1;
    while (!ready) begin
      @(negedge clk); #1;
      cyc++;
    end
    rd = rdata;
    if (w) begin
      ref_mem[a] = d;
      iss_a.push_back(a); iss_d.push_back(d);
    end
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [31:0] a, int exp_stall);
    logic [31:0] v; int c;
    access(1'b0, a, '0, v, c);
    check({tag, " data"}, v, ref_get(a));
    if (exp_stall == 0) check({tag, " no stall"}, c, 0);
    else if (exp_stall > 0) check({tag, " stalled"}, 32'(c >= exp_stall), 1);
  endtask

  task automatic wait_idle();
    repeat (150) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v; int c; int n;
    logic [31:0] A, B, C, D, E;
    A = 32'h0000_1230; B = A + 32'h0000_4000; C = 32'h0002_0040;
    D = 32'h0004_0080; E = D + 32'h0000_4000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset mem_req", {31'b0, mem_req}, 0);
    check("R1 reset ready", {31'b0, ready}, 0);

    // R1 / R3: first access misses and refills in ascending word order
    rd_log.delete();
    rd_chk("R1 first read", A, 4);
    check("R3 refill count", rd_log.size(), 4);
    for (int k = 0; k < 4; k++)
      if (k < rd_log.size()) check("R3 refill order", rd_log[k], (A & 32'hFFFF_FFF0) + 32'(4*k));

    // R4: hits in the same block
    rd_log.delete();
    rd_chk("R4 hit word", A, 0);
    rd_chk("R4 hit other word", A + 4, 0);
    rd_chk("R4 hit last word", (A & 32'hFFFF_FFF0) + 12, 0);
    check("R4 no mem traffic", rd_log.size(), 0);

    // R2: same index, different tag replaces line
    rd_chk("R2 alias read", B, 4);
    rd_chk("R2 alias reread", B, 0);
    rd_chk("R2 original evicted", A, 4);
    rd_chk("R2 other index still cold", A + 16, 4);

    // R5: write hit
    access(1'b1, A, 32'hDEAD_0001, v, c);
    check("R5 write hit no stall", c, 0);
    rd_chk("R5 readback", A, 0);
    wait_idle();
    check("R5 memory updated", mem_get(A), 32'hDEAD_0001);

    // R8: write miss allocates then merges
    rd_log.delete();
    access(1'b1, C + 4, 32'hBEEF_0002, v, c);
    check("R8 write miss stalled", 32'(c >= 4), 1);
    check("R8 refill reads", rd_log.size(), 4);
    rd_chk("R8 merged word", C + 4, 0);
    rd_chk("R8 neighbour word", C, 0);
    rd_chk("R8 neighbour word 3", C + 12, 0);
    wait_idle();

    // R6 / R7: slow memory, write bursts
    lat = 8;
    iss_a.delete(); iss_d.delete(); wr_log_a.delete(); wr_log_d.delete();
    for (int k = 0; k < 5; k++) begin
      access(1'b1, A + 32'(4*(k%4)), 32'h1111_0000 + 32'(k), v, c);
      if (k < 4) check("R6 write with free slot", c, 0);
      else       check("R6 write on full buffer waits", 32'(c > 0), 1);
    end
    access(1'b1, A, 32'h2222_0000, v, c);
    access(1'b1, A, 32'h2222_0001, v, c);
    wait_idle();
    check("R7 drain count", wr_log_a.size(), iss_a.size());
    n = (wr_log_a.size() < iss_a.size()) ? wr_log_a.size() : iss_a.size();
    for (int k = 0; k < n; k++) begin
      check("R7 drain addr order", wr_log_a[k], iss_a[k]);
      check("R7 drain data order", wr_log_d[k], iss_d[k]);
    end
    check("R7 last write wins", mem_get(A), 32'h2222_0001);

    // R9: read miss while a write to the block is buffered
    access(1'b1, A, 32'h3333_0000, v, c);
    access(1'b1, A + 8, 32'h3333_0008, v, c);
    rd_chk("R9 evict via alias", B, 4);
    rd_chk("R9 newest data after refill", A, 4);
    rd_chk("R9 newest data word 2", A + 8, 0);
    access(1'b1, D, 32'h4444_0000, v, c);
    rd_chk("R9 alias of buffered block", E, 4);
    rd_chk("R9 buffered block reread", D, 4);
    wait_idle();
    lat = 2;

    // final memory consistency (R5)
    foreach (ref_mem[k]) check("R5 final memory", mem_get(k), ref_mem[k]);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule